// File: doc/BRIEF.md
# Fault-Aware Round-Robin Lane Dispatcher and Result Merger

This block takes a stream of beats, each made of two 8-bit operands and a 3-bit operation code, and spreads them over three external compute lanes in rotation. Each lane is a fixed-latency multicycle unit that returns a 16-bit result a set number of cycles after it is started. The block gathers those results back into one output stream, in the same order the beats arrived, so the output rate matches the input rate.

Every lane has a fault flag. A lane whose flag is high is dropped from the rotation. Its operand and operation buses are forced to zero so that it sleeps, and the rotation shrinks to the healthy lanes. With three healthy lanes each lane sees one beat in three. With two healthy lanes each sees one beat in two. With one healthy lane it takes every beat. With none, beats are dropped. A result whose lane becomes faulty while the beat is in flight is still delivered, with an error sideband bit set.

The rotation is kept as a 2-bit position: first (01), middle (10) or last (00). Position 00 always names the highest healthy lane, so the rotation stays consistent as lanes fail or recover.

Top module: `rrdc_top`

## Requirements
- R1: While rst_ni is low, lane_go_o and out_valid_o are 0 and all lane operand and operation buses are 0. After reset is released, the first beat goes to the lowest-numbered healthy lane.
- R2: With all three lanes healthy, successive beats go to lane 0, then lane 1, then lane 2, and the cycle repeats.
- R3: With exactly two lanes healthy, beats alternate between them, starting with the lower-numbered lane.
- R4: With exactly one lane healthy, every beat goes to that lane.
- R5: With all three lane_fault_i bits high, an accepted beat starts no lane and produces no output.
- R6: Lane k is flagged faulty when lane_fault_i bit k is 1. In the cycle after a clock edge at which its flag is high, that lane's go bit is 0 and its operand and operation slices are all 0.
- R7: A beat presented with in_valid_i high at a clock edge sets exactly one lane_go_o bit k in the next cycle. Lane k receives the beat on lane_a_o[8k+:8], lane_b_o[8k+:8] and lane_op_o[3k+:3]. No go bit rises without a beat.
- R8: Lane k's result is read from lane_res_i[16k+:16] exactly LANE_LAT cycles after its go cycle. It appears on out_data_o with out_valid_o high in the next cycle, LANE_LAT+2 cycles after the beat, and results leave in issue order.
- R9: out_err_o, valid with out_valid_o, equals the fault flag of the lane that produced the result, taken in the cycle that result was read.
- R10: When the healthy set changes, the kept position picks the next lane. With three healthy lanes: first is lane 0, middle is lane 1, last is lane 2. With two: first is the lower lane, and middle or last is the higher lane. With one: that lane. The next beat follows this rule from the new set.
- R11: Cycles with in_valid_i low do not advance the rotation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Beat present |
| in_a_i | input | OP_W | First operand |
| in_b_i | input | OP_W | Second operand |
| in_op_i | input | SEL_W | Operation code, passed to the lane unchanged |
| lane_fault_i | input | 3 | Per-lane fault flag, bit k for lane k |
| lane_go_o | output | 3 | Per-lane start strobe |
| lane_a_o | output | 3*OP_W | First operand per lane, lane k at [k*OP_W +: OP_W] |
| lane_b_o | output | 3*OP_W | Second operand per lane |
| lane_op_o | output | 3*SEL_W | Operation code per lane |
| lane_res_i | input | 3*RES_W | Result per lane, lane k at [k*RES_W +: RES_W] |
| out_valid_o | output | 1 | Merged result valid |
| out_data_o | output | RES_W | Merged result |
| out_err_o | output | 1 | Producing lane was flagged when its result was taken |

## Verification
The checks assume that the lanes honour the fixed latency. They also assume the fault flags are ordinary synchronous levels that can change on any cycle, and that at most LANE_LAT+1 beats are in flight, which follows from the pipelined issue. The stimulus comes from a bench lane model that exposes a valid result only in its exact latency slot and shows a lane-specific junk pattern at all other times. Fault flags are raised and cleared only between clock edges. Random phases change the flag set at random points, including while beats are in flight, so that the sideband and the position rules of R10 are exercised without breaking these premises.

// File: rtl/rrdc_pkg.sv
package rrdc_pkg;
  localparam int unsigned NLANE = 3;

  // rotation position; encoding fixed by the lane ordering rules
  typedef enum logic [1:0] {
    SLOT_LAST  = 2'b00,
    SLOT_FIRST = 2'b01,
    SLOT_MID   = 2'b10
  } slot_e;

  typedef struct packed {
    logic       v;
    logic [1:0] idx;
  } tag_t;

  function automatic logic [1:0] pop3(input logic [NLANE-1:0] m);
    return {1'b0, m[0]} + {1'b0, m[1]} + {1'b0, m[2]};
  endfunction

  function automatic logic [1:0] oh2idx(input logic [NLANE-1:0] oh);
    return oh[2] ? 2'd2 : (oh[1] ? 2'd1 : 2'd0);
  endfunction
endpackage

// File: rtl/rrdc_sched.sv
module rrdc_sched
  import rrdc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [NLANE-1:0] healthy_i,
  output logic             issue_o,
  output logic [NLANE-1:0] sel_o
);
  slot_e            state_q, state_d, nxt;
  logic [1:0]       cnt;
  logic [NLANE-1:0] lo_oh, hi_oh;

  always_comb begin
    cnt   = pop3(healthy_i);
    lo_oh = healthy_i & (~healthy_i + 3'd1);
    hi_oh = healthy_i[2] ? 3'b100 : (healthy_i[1] ? 3'b010 : 3'b001);
    sel_o = '0;
    nxt   = state_q;
    unique case (cnt)
      2'd3: begin
        case (state_q)
          SLOT_FIRST: begin sel_o = 3'b001; nxt = SLOT_MID;   end
          SLOT_MID:   begin sel_o = 3'b010; nxt = SLOT_LAST;  end
          default:    begin sel_o = 3'b100; nxt = SLOT_FIRST; end
        endcase
      end
      2'd2: begin
        // middle position folds onto the higher lane
        if (state_q == SLOT_FIRST) begin
          sel_o = lo_oh; nxt = SLOT_LAST;
        end else begin
          sel_o = hi_oh; nxt = SLOT_FIRST;
        end
      end
      2'd1: begin
        sel_o = healthy_i; nxt = SLOT_LAST;
      end
      default: begin
        sel_o = '0; nxt = state_q;
      end
    endcase
    issue_o = valid_i && (cnt != 2'd0);
    state_d = issue_o ? nxt : state_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SLOT_FIRST;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/rrdc_issue.sv
module rrdc_issue
  import rrdc_pkg::*;
#(
  parameter int unsigned OP_W  = 8,
  parameter int unsigned SEL_W = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   issue_i,
  input  logic [NLANE-1:0]       sel_i,
  input  logic [NLANE-1:0]       fault_i,
  input  logic [OP_W-1:0]        a_i,
  input  logic [OP_W-1:0]        b_i,
  input  logic [SEL_W-1:0]       op_i,
  output logic [NLANE-1:0]       go_o,
  output logic [NLANE*OP_W-1:0]  a_o,
  output logic [NLANE*OP_W-1:0]  b_o,
  output logic [NLANE*SEL_W-1:0] op_o
);
  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    logic             go_q;
    logic [OP_W-1:0]  a_q, b_q;
    logic [SEL_W-1:0] op_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        go_q <= 1'b0;
        a_q  <= '0;
        b_q  <= '0;
        op_q <= '0;
      end else begin
        go_q <= issue_i & sel_i[k];
        if (fault_i[k]) begin
          // sleep: hold the lane inputs quiet
          a_q  <= '0;
          b_q  <= '0;
          op_q <= '0;
        end else if (issue_i && sel_i[k]) begin
          a_q  <= a_i;
          b_q  <= b_i;
          op_q <= op_i;
        end
      end
    end

    assign go_o[k]                 = go_q;
    assign a_o[k*OP_W +: OP_W]     = a_q;
    assign b_o[k*OP_W +: OP_W]     = b_q;
    assign op_o[k*SEL_W +: SEL_W]  = op_q;
  end
endmodule

// File: rtl/rrdc_merge.sv
module rrdc_merge
  import rrdc_pkg::*;
#(
  parameter int unsigned RES_W    = 16,
  parameter int unsigned LANE_LAT = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   issue_i,
  input  logic [NLANE-1:0]       sel_i,
  input  logic [NLANE-1:0]       fault_i,
  input  logic [NLANE*RES_W-1:0] res_i,
  output logic                   valid_o,
  output logic [RES_W-1:0]       data_o,
  output logic                   err_o
);
  // one slot per cycle between issue and result sampling
  localparam int unsigned DEPTH = LANE_LAT + 1;

  tag_t             tag_q [DEPTH];
  tag_t             head;
  logic [RES_W-1:0] pick_res;
  logic             pick_err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) tag_q[i] <= '0;
    end else begin
      tag_q[0] <= '{v: issue_i, idx: oh2idx(sel_i)};
      for (int i = 1; i < DEPTH; i++) tag_q[i] <= tag_q[i-1];
    end
  end

  assign head = tag_q[DEPTH-1];

  always_comb begin
    case (head.idx)
      2'd1:    begin pick_res = res_i[1*RES_W +: RES_W]; pick_err = fault_i[1]; end
      2'd2:    begin pick_res = res_i[2*RES_W +: RES_W]; pick_err = fault_i[2]; end
      default: begin pick_res = res_i[0 +: RES_W];       pick_err = fault_i[0]; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= head.v;
      if (head.v) begin
        data_o <= pick_res;
        err_o  <= pick_err;
      end
    end
  end
endmodule

// File: rtl/rrdc_top.sv
module rrdc_top
  import rrdc_pkg::*;
#(
  parameter int unsigned OP_W     = 8,
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned RES_W    = 16,
  parameter int unsigned LANE_LAT = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_valid_i,
  input  logic [OP_W-1:0]        in_a_i,
  input  logic [OP_W-1:0]        in_b_i,
  input  logic [SEL_W-1:0]       in_op_i,
  input  logic [2:0]             lane_fault_i,
  output logic [2:0]             lane_go_o,
  output logic [3*OP_W-1:0]      lane_a_o,
  output logic [3*OP_W-1:0]      lane_b_o,
  output logic [3*SEL_W-1:0]     lane_op_o,
  input  logic [3*RES_W-1:0]     lane_res_i,
  output logic                   out_valid_o,
  output logic [RES_W-1:0]       out_data_o,
  output logic                   out_err_o
);
  logic             issue;
  logic [NLANE-1:0] sel;

  rrdc_sched u_sched (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (in_valid_i),
    .healthy_i (~lane_fault_i),
    .issue_o   (issue),
    .sel_o     (sel)
  );

  rrdc_issue #(.OP_W(OP_W), .SEL_W(SEL_W)) u_issue (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (issue),
    .sel_i   (sel),
    .fault_i (lane_fault_i),
    .a_i     (in_a_i),
    .b_i     (in_b_i),
    .op_i    (in_op_i),
    .go_o    (lane_go_o),
    .a_o     (lane_a_o),
    .b_o     (lane_b_o),
    .op_o    (lane_op_o)
  );

  rrdc_merge #(.RES_W(RES_W), .LANE_LAT(LANE_LAT)) u_merge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (issue),
    .sel_i   (sel),
    .fault_i (lane_fault_i),
    .res_i   (lane_res_i),
    .valid_o (out_valid_o),
    .data_o  (out_data_o),
    .err_o   (out_err_o)
  );
endmodule

// File: rtl/rrdc_chk.sv
module rrdc_chk #(
  parameter int unsigned OP_W     = 8,
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned RES_W    = 16,
  parameter int unsigned LANE_LAT = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 in_valid_i,
  input logic [2:0]           lane_fault_i,
  input logic [2:0]           lane_go_o,
  input logic [3*OP_W-1:0]    lane_a_o,
  input logic [3*OP_W-1:0]    lane_b_o,
  input logic [3*SEL_W-1:0]   lane_op_o,
  input logic                 out_valid_o
);
  logic       seen_q;
  logic [7:0] inflight_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q     <= 1'b0;
      inflight_q <= '0;
    end else begin
      seen_q     <= 1'b1;
      inflight_q <= inflight_q + {7'd0, |lane_go_o} - {7'd0, out_valid_o};
    end
  end

  a_r7_onehot_go: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lane_go_o));

  a_r7_go_needs_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && |lane_go_o) |-> $past(in_valid_i));

  a_r6_no_go_faulty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> ((lane_go_o & $past(lane_fault_i)) == 3'b000));

  a_r5_dead_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(&lane_fault_i)) |-> (lane_go_o == 3'b000));

  a_r4_single_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(in_valid_i) && ($countones(~$past(lane_fault_i)) == 1))
      |-> (lane_go_o == ~$past(lane_fault_i)));

  for (genvar k = 0; k < 3; k++) begin : g_sleep
    a_r6_sleep_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen_q && $past(lane_fault_i[k])) |->
        (lane_a_o[k*OP_W +: OP_W] == '0 && lane_b_o[k*OP_W +: OP_W] == '0 &&
         lane_op_o[k*SEL_W +: SEL_W] == '0));
  end

  a_r8_inflight_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight_q <= 8'(LANE_LAT + 1));

  a_r8_no_orphan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (inflight_q != 8'd0));
endmodule

bind rrdc_top rrdc_chk #(
  .OP_W(OP_W), .SEL_W(SEL_W), .RES_W(RES_W), .LANE_LAT(LANE_LAT)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_valid_i   (in_valid_i),
  .lane_fault_i (lane_fault_i),
  .lane_go_o    (lane_go_o),
  .lane_a_o     (lane_a_o),
  .lane_b_o     (lane_b_o),
  .lane_op_o    (lane_op_o),
  .out_valid_o  (out_valid_o)
);

// File: tb/rrdc_top_tb.sv
module rrdc_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [7:0]  in_a_i = '0, in_b_i = '0;
  logic [2:0]  in_op_i = '0;
  logic [2:0]  lane_fault_i = '0;
  logic [2:0]  lane_go_o;
  logic [23:0] lane_a_o, lane_b_o;
  logic [8:0]  lane_op_o;
  logic [47:0] lane_res_i;
  logic        out_valid_o;
  logic [15:0] out_data_o;
  logic        out_err_o;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rrdc_top #(.LANE_LAT(LAT)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_a_i(in_a_i),
    .in_b_i(in_b_i), .in_op_i(in_op_i), .lane_fault_i(lane_fault_i),
    .lane_go_o(lane_go_o), .lane_a_o(lane_a_o), .lane_b_o(lane_b_o),
    .lane_op_o(lane_op_o), .lane_res_i(lane_res_i), .out_valid_o(out_valid_o),
    .out_data_o(out_data_o), .out_err_o(out_err_o)
  );

  function automatic logic [15:0] alu_ref(input logic [2:0] op, input logic [7:0] a, b);
    case (op)
      3'd0: return {8'd0, a} + {8'd0, b};
      3'd1: return {8'd0, a | b};
      3'd2: return {8'd0, a} - {8'd0, b};
      3'd3: return {8'd0, a & b};
      3'd4: return {8'd0, a ^ b};
      3'd5: return {8'd0, ~(a ^ b)};
      3'd6: return {8'd0, a} * {8'd0, b};
      default: return 16'd0;
    endcase
  endfunction

  // lane models: result visible only in the exact latency slot
  logic [LAT-1:0]       st_v [3];
  logic [LAT-1:0][15:0] st_d [3];
  always @(posedge clk) begin
    for (int k = 0; k < 3; k++) begin
      st_v[k] <= {st_v[k][LAT-2:0], lane_go_o[k]};
      st_d[k] <= {st_d[k][LAT-2:0],
                  alu_ref(lane_op_o[k*3 +: 3], lane_a_o[k*8 +: 8], lane_b_o[k*8 +: 8])};
    end
  end
  initial for (int k = 0; k < 3; k++) begin st_v[k] = '0; st_d[k] = '0; end
  always_comb
    for (int k = 0; k < 3; k++)
      lane_res_i[k*16 +: 16] = st_v[k][LAT-1] ? st_d[k][LAT-1] : (16'hDEA0 ^ 16'(k * 16'h1111));

  // expectation rings indexed by cycle
  logic [2:0]  exp_go [16];
  logic [7:0]  exp_a [16], exp_b [16];
  logic [2:0]  exp_op [16];
  logic [2:0]  exp_zero [16];
  string       exp_tag [16];
  logic        exp_ov [16];
  logic [15:0] exp_od [16];
  logic [1:0]  exp_ol [16];
  logic [2:0]  flt_hist [16];

  logic [1:0] bst = 2'b01;
  logic [2:0] last_h = 3'b111;
  bit prev_v = 1, after_rst = 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s cyc=%0d actual=%0h expected=%0h", req, what, cyc, act, exp);
    end
  endtask

  task automatic clear_rings();
    for (int i = 0; i < 16; i++) begin
      exp_go[i] = '0; exp_zero[i] = '0; exp_ov[i] = 0; exp_tag[i] = "R7";
      flt_hist[i] = '0; exp_a[i] = '0; exp_b[i] = '0; exp_op[i] = '0;
      exp_od[i] = '0; exp_ol[i] = '0;
    end
  endtask

  // position rule: 01 first, 10 middle, 00 last among healthy lanes, ascending
  function automatic logic [3:0] ref_pick(input logic [1:0] st, input logic [2:0] h);
    int list [3]; int n = 0; int pos; int np; logic [1:0] ns;
    for (int k = 0; k < 3; k++) if (h[k]) begin list[n] = k; n++; end
    if (n == 0) return {2'd3, st};
    if (st == 2'b01)      pos = 0;
    else if (st == 2'b10) pos = (n == 3) ? 1 : n - 1;
    else                  pos = n - 1;
    np = (pos + 1) % n;
    if (np == n - 1)  ns = 2'b00;
    else if (np == 0) ns = 2'b01;
    else              ns = 2'b10;
    return {2'(list[pos]), ns};
  endfunction

  task automatic check_reset_state();
    chk(lane_go_o === 3'b000, "R1", "go in reset", 32'(lane_go_o), 0);
    chk(out_valid_o === 1'b0, "R1", "out_valid in reset", 32'(out_valid_o), 0);
    chk({lane_a_o, lane_b_o, lane_op_o} === '0, "R1", "lane buses in reset",
        32'(lane_a_o), 0);
  endtask

  task automatic step(input bit v, input logic [7:0] a, input logic [7:0] b,
                      input logic [2:0] op, input logic [2:0] f);
    int s = cyc % 16;
    int s1 = (cyc + 1) % 16;
    int so = (cyc + LAT + 2) % 16;
    logic [2:0] h = ~f;
    logic [3:0] pk;
    logic e_err;
    string tg;
    // outputs of the current cycle
    chk(lane_go_o === exp_go[s], exp_tag[s], "go", 32'(lane_go_o), 32'(exp_go[s]));
    for (int k = 0; k < 3; k++) begin
      if (exp_go[s][k]) begin
        chk(lane_a_o[k*8 +: 8] === exp_a[s], "R7", "lane a", 32'(lane_a_o[k*8 +: 8]), 32'(exp_a[s]));
        chk(lane_b_o[k*8 +: 8] === exp_b[s], "R7", "lane b", 32'(lane_b_o[k*8 +: 8]), 32'(exp_b[s]));
        chk(lane_op_o[k*3 +: 3] === exp_op[s], "R7", "lane op", 32'(lane_op_o[k*3 +: 3]), 32'(exp_op[s]));
      end
      if (exp_zero[s][k])
        chk({lane_a_o[k*8 +: 8], lane_b_o[k*8 +: 8], lane_op_o[k*3 +: 3]} === '0, "R6",
            "sleep buses", 32'({lane_a_o[k*8 +: 8], lane_b_o[k*8 +: 8]}), 0);
    end
    chk(out_valid_o === exp_ov[s], "R8", "out_valid", 32'(out_valid_o), 32'(exp_ov[s]));
    if (exp_ov[s]) begin
      chk(out_data_o === exp_od[s], "R8", "out_data", 32'(out_data_o), 32'(exp_od[s]));
      e_err = flt_hist[(cyc + 15) % 16][exp_ol[s]];
      chk(out_err_o === e_err, "R9", "out_err", 32'(out_err_o), 32'(e_err));
    end
    exp_ov[s] = 0;
    // expectations for the beat driven now
    exp_zero[s1] = f;
    exp_go[s1] = '0;
    exp_tag[s1] = "R7";
    if (v) begin
      case ($countones(h))
        3: tg = "R2";
        2: tg = "R3";
        1: tg = "R4";
        default: tg = "R5";
      endcase
      if (after_rst) tg = "R1";
      else if (h != last_h) tg = "R10";
      else if (!prev_v) tg = "R11";
      exp_tag[s1] = tg;
      pk = ref_pick(bst, h);
      if (pk[3:2] != 2'd3) begin
        exp_go[s1][pk[3:2]] = 1'b1;
        exp_a[s1] = a; exp_b[s1] = b; exp_op[s1] = op;
        exp_ov[so] = 1; exp_od[so] = alu_ref(op, a, b); exp_ol[so] = pk[3:2];
        bst = pk[1:0];
      end
      last_h = h;
      after_rst = 0;
    end
    prev_v = v;
    flt_hist[cyc % 16] = f;
    in_valid_i = v; in_a_i = a; in_b_i = b; in_op_i = op; lane_fault_i = f;
    @(negedge clk);
    cyc++;
  endtask

  task automatic do_reset();
    rst_ni = 0;
    in_valid_i = 0; lane_fault_i = '0;
    @(negedge clk);
    check_reset_state();
    @(negedge clk);
    check_reset_state();
    clear_rings();
    bst = 2'b01; after_rst = 1; prev_v = 1; last_h = 3'b111;
    rst_ni = 1;
  endtask

  function automatic logic [2:0] rand_fault();
    int r = $urandom % 8;
    case (r)
      0, 1, 2, 3: return 3'b000;
      4, 5: return 3'(1 << ($urandom % 3));
      6: return ~3'(1 << ($urandom % 3));
      default: return 3'($urandom);
    endcase
  endfunction

  initial begin
    logic [2:0] f;
    void'($urandom(32'd20240611));
    clear_rings();
    @(negedge clk);
    check_reset_state();
    do_reset();
    // R2: three healthy, operand corners
    step(1, 8'hFF, 8'hFF, 3'd6, 3'b000);
    step(1, 8'hFF, 8'h01, 3'd0, 3'b000);
    step(1, 8'h00, 8'h01, 3'd2, 3'b000);
    for (int i = 0; i < 9; i++) step(1, 8'(i * 29 + 3), 8'(i * 17), 3'(i % 7), 3'b000);
    // R11: gaps
    step(0, 0, 0, 0, 3'b000); step(1, 8'h11, 8'h22, 3'd1, 3'b000);
    step(0, 0, 0, 0, 3'b000); step(0, 0, 0, 0, 3'b000);
    step(1, 8'h33, 8'h44, 3'd4, 3'b000); step(1, 8'h55, 8'h66, 3'd5, 3'b000);
    // R3: lane 2 faulty, then lane 0 faulty
    for (int i = 0; i < 8; i++) step(1, 8'(i + 1), 8'(i * 3), 3'd0, 3'b100);
    for (int i = 0; i < 8; i++) step(1, 8'(i + 7), 8'(i * 5), 3'd3, 3'b001);
    // R4: single survivors
    for (int i = 0; i < 6; i++) step(1, 8'(i * 11), 8'(i + 9), 3'd6, 3'b110);
    for (int i = 0; i < 6; i++) step(1, 8'(i * 13), 8'(i + 2), 3'd2, 3'b011);
    // R5: all faulty
    for (int i = 0; i < 8; i++) step(1, 8'hAA, 8'h55, 3'd0, 3'b111);
    // R9/R10: flag rises while beats are in flight
    for (int i = 0; i < 4; i++) step(1, 8'(i + 40), 8'(i + 50), 3'd0, 3'b000);
    for (int i = 0; i < 8; i++) step(1, 8'(i + 60), 8'(i + 70), 3'd4, 3'b010);
    for (int i = 0; i < 8; i++) step(1, 8'(i + 80), 8'(i + 90), 3'd1, 3'b000);
    // R1: reset mid-stream with one lane faulty afterwards
    do_reset();
    for (int i = 0; i < 6; i++) step(1, 8'(i + 3), 8'(i + 4), 3'd0, 3'b001);
    // random phase
    f = 3'b000;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 30 == 0) f = rand_fault();
      step(($urandom % 4) != 0, 8'($urandom), 8'($urandom), 3'($urandom % 7), f);
    end
    for (int i = 0; i < LAT + 4; i++) step(0, 0, 0, 0, 3'b000);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired at cyc=%0d actual=running expected=finished", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule